// File: doc/BRIEF.md
# Programmable 16-bit Root Counter

This block is a 16-bit up-counter. A small register port gives access to three registers: the count, the mode and the target. Each system clock, the counter can advance by one. Whether it does depends on the selected count source and on the sync rules. The source is either every system clock or an alternate tick. The instance variant fixes which alternate tick is used. The pixel and line variants use an external tick pulse on `alt_tick_i`. The divide variant uses an internal tick that fires on every eighth system clock.

Two events come out of the counter. A target event occurs when the counter advances while it equals the target. An overflow event occurs when it advances from 0xFFFF and wraps to 0. Each event sets a sticky flag in the mode register. A read of the mode register through the read strobe clears both flags. Each event can also raise a one-cycle interrupt pulse toward an external interrupt controller. Unless the repeat bit is set, only the first interrupt after a mode write is raised.

A sync field lets an external blanking signal pause or zero the counter. On the divide variant, two of the sync encodings freeze the counter instead.

Top module: `rt_root_counter`

## Requirements
- R1: While `rst_n` is low and just after it rises, every register reads 0 and `irq_o` is low.
- R2: Register addresses: 0 is the count, 1 is the mode and 2 is the target. A write to the count loads the 16-bit value. With mode 0, the count then advances by one on every system clock. The count reads back as 16 bits.
- R3: Bit 8 selects the alternate source on the pixel and line variants. The count then advances only on clocks where `alt_tick_i` is high. Bit 9 selects the divided source on the divide variant. The count then advances on every eighth clock, counted from the last mode write, so the first advance comes at the eighth edge after the write.
- R4: Advancing from 0xFFFF gives 0 and sets the overflow flag at mode bit 12.
- R5: Advancing while the count equals the target sets the target flag at mode bit 11. If mode bit 3 is set, the count becomes 0. Otherwise it goes on to the next value.
- R6: Mode bit 10 is set by every target or overflow event. Only a mode write clears it.
- R7: A mode read with `rd_en_i` returns the full value, then clears bits 11 and 12. An event on the same edge leaves its flag set.
- R8: A mode write does five things: it stores bits 9:0, zeroes the count, clears bits 10 to 12, forgets earlier interrupts and restarts the divider. Bits 15:13 always read 0.
- R9: A target write leaves the count unchanged.
- R10: `irq_o` pulses high for one cycle, on the clock after the event. A target event raises it only when bit 4 is set, and an overflow event only when bit 5 is set. With bit 6 clear, only the first such pulse after a mode write is raised.
- R11: With bit 6 set, every enabled event produces a pulse.
- R12: On the pixel and line variants, sync is enabled by bit 0. The field in bits 2:1 then selects one of four behaviours. Field 0 pauses the count while `blank_i` is high. Field 1 zeroes it on each rising edge of `blank_i`. Field 2 zeroes it on each rising edge and lets it run only while `blank_i` is high. Field 3 holds it until the first rising edge after the mode write, and then it runs freely.
- R13: On the divide variant with bit 0 set, fields 0 and 3 freeze the count. Fields 1 and 2 let it run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Register select: 0 count, 1 mode, 2 target |
| wr_en_i | input | 1 | Write strobe, one cycle per access |
| rd_en_i | input | 1 | Read strobe, triggers the read side effect |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data of the selected register (combinational) |
| alt_tick_i | input | 1 | Pixel or line tick (pixel and line variants) |
| blank_i | input | 1 | External blanking level for sync modes |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
Two instances run side by side from the same stimulus: a line variant and a divide variant. A behavioural model predicts both instances on every clock. The alternate tick is a pseudo-random bit stream and the blanking input is periodic, so the pixel/line source and the divided source give visibly different counts under one mode. The tests cover several cases:
- Counts placed just below 0xFFFF and small targets, with and without restart, which tell the overflow path apart from the target path.
- Repeated mode reads during target hits, which tell a clean read-clear apart from one that loses a same-edge event.
- All four sync fields, swept while blanking toggles, which separate pause, zero-on-edge, gated-run, wait-then-run and the divide variant's freeze.

// File: rtl/rt_pkg.sv
package rt_pkg;

   localparam int unsigned RT_DW    = 16;
   localparam int unsigned RT_CFG_W = 10;

   typedef enum logic [1:0] {
      RT_REG_COUNT  = 2'd0,
      RT_REG_MODE   = 2'd1,
      RT_REG_TARGET = 2'd2,
      RT_REG_NONE   = 2'd3
   } rt_reg_e;

   typedef enum logic [1:0] {
      RT_VAR_PIXEL = 2'd0,
      RT_VAR_LINE  = 2'd1,
      RT_VAR_DIV   = 2'd2
   } rt_variant_e;

   // stored configuration, bit 0 at the bottom
   typedef struct packed {
      logic       div8;       // 9
      logic       alt;        // 8
      logic       spare7;     // 7
      logic       rep_irq;    // 6
      logic       irq_wrap;   // 5
      logic       irq_hit;    // 4
      logic       clr_on_hit; // 3
      logic [1:0] sync_sel;   // 2:1
      logic       sync_on;    // 0
   } rt_cfg_t;

endpackage

// File: rtl/rt_tick_gen.sv
module rt_tick_gen #(
   parameter bit          IS_DIV   = 1'b0,
   parameter int unsigned DIV_LOG2 = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic alt_on,
   input  logic ext_tick,
   output logic tick_en
);

   logic [DIV_LOG2-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pre_q <= '0;
      else if (restart) pre_q <= '0;
      else              pre_q <= pre_q + 1'b1;
   end

   always_comb begin
      if (!alt_on)     tick_en = 1'b1;
      else if (IS_DIV) tick_en = &pre_q;
      else             tick_en = ext_tick;
   end

endmodule

// File: rtl/rt_sync_ctl.sv
module rt_sync_ctl #(
   parameter bit IS_DIV = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic       sync_on,
   input  logic [1:0] sync_sel,
   input  logic       blank,
   output logic       run,
   output logic       zero_req
);

   logic blank_q;
   logic armed_q;
   logic blank_rise;

   assign blank_rise = blank & ~blank_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blank_q <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         blank_q <= blank;
         if (restart)         armed_q <= 1'b0;
         else if (blank_rise) armed_q <= 1'b1;
      end
   end

   always_comb begin
      run      = 1'b1;
      zero_req = 1'b0;
      if (sync_on) begin
         if (IS_DIV) begin
            run = (sync_sel == 2'd1) || (sync_sel == 2'd2);
         end else begin
            unique case (sync_sel)
               2'd0: run = ~blank;
               2'd1: run = 1'b1;
               2'd2: run = blank;
               2'd3: run = armed_q;
            endcase
            zero_req = blank_rise && ((sync_sel == 2'd1) || (sync_sel == 2'd2));
         end
      end
   end

endmodule

// File: rtl/rt_count_core.sv
module rt_count_core #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             clear,
   input  logic             step,
   input  logic             rst_on_hit,
   input  logic [CNT_W-1:0] target,
   output logic [CNT_W-1:0] cnt_o,
   output logic             hit_o,
   output logic             wrap_o
);

   logic [CNT_W-1:0] cnt_q;

   assign cnt_o  = cnt_q;
   assign hit_o  = step && (cnt_q == target);
   assign wrap_o = step && (&cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (load)       cnt_q <= load_val;
      else if (clear)      cnt_q <= '0;
      else if (step) begin
         if (hit_o && rst_on_hit) cnt_q <= '0;
         else                     cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/rt_root_counter.sv
module rt_root_counter
   import rt_pkg::*;
#(
   parameter rt_variant_e VARIANT  = RT_VAR_LINE,
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned DIV_LOG2 = 3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  addr_i,
   input  logic        wr_en_i,
   input  logic        rd_en_i,
   input  logic [15:0] wdata_i,
   output logic [15:0] rdata_o,
   input  logic        alt_tick_i,
   input  logic        blank_i,
   output logic        irq_o
);

   localparam bit IS_DIV = (VARIANT == RT_VAR_DIV);

   if (CNT_W < 4 || CNT_W > RT_DW) begin : g_bad_cnt_w
      $error("rt_root_counter: CNT_W must lie in 4..16");
   end
   if (DIV_LOG2 < 1 || DIV_LOG2 > 8) begin : g_bad_div
      $error("rt_root_counter: DIV_LOG2 must lie in 1..8");
   end

   rt_cfg_t          cfg_q;
   logic [CNT_W-1:0] tgt_q;
   logic [CNT_W-1:0] cnt;
   logic             hit_f_q, wrap_f_q, evt_f_q, fired_q, irq_q;

   rt_reg_e reg_sel;
   logic    mode_wr, cnt_wr, tgt_wr, mode_rd, any_wr;
   logic    alt_on, tick_en, run, zero_req, step, zero;
   logic    hit_ev, wrap_ev, fire;

   assign reg_sel = rt_reg_e'(addr_i);
   assign mode_wr = wr_en_i && (reg_sel == RT_REG_MODE);
   assign cnt_wr  = wr_en_i && (reg_sel == RT_REG_COUNT);
   assign tgt_wr  = wr_en_i && (reg_sel == RT_REG_TARGET);
   assign mode_rd = rd_en_i && !wr_en_i && (reg_sel == RT_REG_MODE);
   assign any_wr  = mode_wr || cnt_wr;

   assign alt_on  = IS_DIV ? cfg_q.div8 : cfg_q.alt;

   rt_tick_gen #(
      .IS_DIV  (IS_DIV),
      .DIV_LOG2(DIV_LOG2)
   ) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (mode_wr),
      .alt_on  (alt_on),
      .ext_tick(alt_tick_i),
      .tick_en (tick_en)
   );

   rt_sync_ctl #(
      .IS_DIV(IS_DIV)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (mode_wr),
      .sync_on (cfg_q.sync_on),
      .sync_sel(cfg_q.sync_sel),
      .blank   (blank_i),
      .run     (run),
      .zero_req(zero_req)
   );

   assign step = run && tick_en && !zero_req && !any_wr;
   assign zero = zero_req && !any_wr;

   rt_count_core #(
      .CNT_W(CNT_W)
   ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (cnt_wr),
      .load_val  (wdata_i[CNT_W-1:0]),
      .clear     (mode_wr || zero),
      .step      (step),
      .rst_on_hit(cfg_q.clr_on_hit),
      .target    (tgt_q),
      .cnt_o     (cnt),
      .hit_o     (hit_ev),
      .wrap_o    (wrap_ev)
   );

   assign fire = ((hit_ev && cfg_q.irq_hit) || (wrap_ev && cfg_q.irq_wrap))
                 && (cfg_q.rep_irq || !fired_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q    <= '0;
         tgt_q    <= '0;
         hit_f_q  <= 1'b0;
         wrap_f_q <= 1'b0;
         evt_f_q  <= 1'b0;
         fired_q  <= 1'b0;
         irq_q    <= 1'b0;
      end else begin
         irq_q <= fire;
         if (tgt_wr) tgt_q <= wdata_i[CNT_W-1:0];
         if (mode_wr) begin
            cfg_q    <= rt_cfg_t'(wdata_i[RT_CFG_W-1:0]);
            hit_f_q  <= 1'b0;
            wrap_f_q <= 1'b0;
            evt_f_q  <= 1'b0;
            fired_q  <= 1'b0;
         end else begin
            hit_f_q  <= hit_ev  || (hit_f_q  && !mode_rd);
            wrap_f_q <= wrap_ev || (wrap_f_q && !mode_rd);
            evt_f_q  <= evt_f_q || hit_ev || wrap_ev;
            fired_q  <= fired_q || fire;
         end
      end
   end

   assign irq_o = irq_q;

   always_comb begin
      unique case (reg_sel)
         RT_REG_COUNT:  rdata_o = RT_DW'(cnt);
         RT_REG_MODE:   rdata_o = {3'b000, wrap_f_q, hit_f_q, evt_f_q, cfg_q};
         RT_REG_TARGET: rdata_o = RT_DW'(tgt_q);
         default:       rdata_o = '0;
      endcase
   end

endmodule

// File: rtl/rt_root_counter_chk.sv
module rt_root_counter_chk #(
   parameter int unsigned CNT_W  = 16,
   parameter bit          IS_DIV = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq_o,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] target,
   input logic [9:0]       cfg,
   input logic             hit_flag,
   input logic             wrap_flag,
   input logic             evt_flag,
   input logic             step,
   input logic             zero,
   input logic             mode_wr,
   input logic             mode_rd,
   input logic             cnt_wr,
   input logic             tgt_wr
);

   AST_MODE_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr |=> (cnt == '0) && !hit_flag && !wrap_flag && !evt_flag); // R8

   AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (step && (&cnt)) |=> (cnt == '0) && wrap_flag && evt_flag); // R4

   AST_HIT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (step && (cnt == target) && cfg[3]) |=> (cnt == '0) && hit_flag); // R5

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_rd && !step) |=> !hit_flag && !wrap_flag); // R7

   AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !cfg[6]) |=> !irq_o); // R10

   AST_IRQ_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(step)); // R10

   AST_TARGET_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_wr && !step && !zero) |=> (cnt == $past(cnt))); // R9

   if (IS_DIV) begin : g_div_stop
      AST_DIV_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg[0] && (cfg[2:1] == 2'd0 || cfg[2:1] == 2'd3) && !cnt_wr && !mode_wr)
         |=> $stable(cnt)); // R13
   end

endmodule

bind rt_root_counter rt_root_counter_chk #(
   .CNT_W (CNT_W),
   .IS_DIV(IS_DIV)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_o    (irq_o),
   .cnt      (cnt),
   .target   (tgt_q),
   .cfg      (cfg_q),
   .hit_flag (hit_f_q),
   .wrap_flag(wrap_f_q),
   .evt_flag (evt_f_q),
   .step     (step),
   .zero     (zero),
   .mode_wr  (mode_wr),
   .mode_rd  (mode_rd),
   .cnt_wr   (cnt_wr),
   .tgt_wr   (tgt_wr)
);

// File: tb/rt_root_counter_tb_top.sv
`timescale 1ns/1ps
module rt_root_counter_tb_top;
   import rt_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic        wr = 1'b0;
   logic        rd = 1'b0;
   logic [15:0] wdata = 16'h0;
   logic        alt_tick = 1'b0;
   logic        blank = 1'b0;
   logic [15:0] rdata_line, rdata_div;
   logic        irq_line, irq_div;

   int    n_checks = 0;
   int    n_fail   = 0;
   string cur_req  = "R1";
   bit    finished = 1'b0;

   always #10 clk = ~clk;

   rt_root_counter #(.VARIANT(RT_VAR_LINE)) dut_i (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr), .rd_en_i(rd),
      .wdata_i(wdata), .rdata_o(rdata_line), .alt_tick_i(alt_tick),
      .blank_i(blank), .irq_o(irq_line));

   rt_root_counter #(.VARIANT(RT_VAR_DIV)) dut_div_i (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr), .rd_en_i(rd),
      .wdata_i(wdata), .rdata_o(rdata_div), .alt_tick_i(alt_tick),
      .blank_i(blank), .irq_o(irq_div));

   // background stimulus: pseudo-random tick, periodic blanking (5 of 23)
   logic [7:0] lfsr = 8'hA5;
   int         bphase = 0;
   always @(negedge clk) begin
      lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      alt_tick <= lfsr[0];
      bphase   <= (bphase + 1) % 23;
      blank    <= (bphase < 5);
   end

   // reference model, index 0 = line variant, 1 = divide variant
   int m_cnt[2], m_tgt[2], m_cfg[2], m_div[2];
   bit m_hit[2], m_wrap[2], m_evt[2], m_fired[2], m_irq[2], m_bq[2], m_arm[2];

   initial for (int k = 0; k < 2; k++) begin
      m_cnt[k] = 0; m_tgt[k] = 0; m_cfg[k] = 0; m_div[k] = 0;
      m_hit[k] = 0; m_wrap[k] = 0; m_evt[k] = 0; m_fired[k] = 0;
      m_irq[k] = 0; m_bq[k] = 0; m_arm[k] = 0;
   end

   task automatic model_edge(input int k);
      bit isdiv, mw, cw, tw, mr, alt, src, rise, sy, run, zr, st, hit, ovf, fire;
      int f;
      isdiv = (k == 1);
      if (!rst_n) begin
         m_cnt[k] = 0; m_tgt[k] = 0; m_cfg[k] = 0; m_div[k] = 0;
         m_hit[k] = 0; m_wrap[k] = 0; m_evt[k] = 0; m_fired[k] = 0;
         m_irq[k] = 0; m_bq[k] = 0; m_arm[k] = 0;
         return;
      end
      mw = wr && addr == 2'd1;
      cw = wr && addr == 2'd0;
      tw = wr && addr == 2'd2;
      mr = rd && !wr && addr == 2'd1;
      alt = isdiv ? m_cfg[k][9] : m_cfg[k][8];
      src = !alt ? 1'b1 : (isdiv ? (m_div[k] == 7) : alt_tick);
      rise = blank && !m_bq[k];
      sy = m_cfg[k][0];
      f  = (m_cfg[k] >> 1) & 3;
      if (isdiv) begin
         run = !sy || f == 1 || f == 2;
         zr  = 1'b0;
      end else begin
         run = !sy || (f == 0 && !blank) || f == 1 || (f == 2 && blank) || (f == 3 && m_arm[k]);
         zr  = sy && (f == 1 || f == 2) && rise;
      end
      st  = run && src && !zr && !mw && !cw;
      zr  = zr && !mw && !cw;
      hit = st && (m_cnt[k] == m_tgt[k]);
      ovf = st && (m_cnt[k] == 65535);
      fire = st && ((hit && m_cfg[k][4]) || (ovf && m_cfg[k][5])) && (m_cfg[k][6] || !m_fired[k]);
      m_irq[k] = fire;
      if (cw)      m_cnt[k] = wdata;
      else if (mw) m_cnt[k] = 0;
      else if (zr) m_cnt[k] = 0;
      else if (st) m_cnt[k] = (hit && m_cfg[k][3]) ? 0 : ((m_cnt[k] + 1) & 16'hFFFF);
      if (mw) begin
         m_cfg[k] = wdata & 16'h03FF;
         m_hit[k] = 0; m_wrap[k] = 0; m_evt[k] = 0; m_fired[k] = 0;
      end else begin
         if (mr) begin m_hit[k] = 0; m_wrap[k] = 0; end
         if (hit) m_hit[k] = 1;
         if (ovf) m_wrap[k] = 1;
         if (hit || ovf) m_evt[k] = 1;
         if (fire) m_fired[k] = 1;
      end
      if (tw) m_tgt[k] = wdata;
      m_div[k] = mw ? 0 : ((m_div[k] + 1) & 7);
      m_arm[k] = mw ? 1'b0 : (rise ? 1'b1 : m_arm[k]);
      m_bq[k]  = blank;
   endtask

   always @(posedge clk) begin
      model_edge(0);
      model_edge(1);
   end

   function automatic int exp_rdata(input int k);
      case (addr)
         2'd0: return m_cnt[k];
         2'd1: return (int'(m_wrap[k]) << 12) | (int'(m_hit[k]) << 11) |
                      (int'(m_evt[k]) << 10) | m_cfg[k];
         2'd2: return m_tgt[k];
         default: return 0;
      endcase
   endfunction

   task automatic check(input string what, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0h expected %0h at %0t", cur_req, what, got, exp, $time);
      end
   endtask

   // compare every clock, after the negedge stimulus has settled
   always @(negedge clk) begin
      #5;
      if (!finished) begin
         check("line rdata", int'(rdata_line), exp_rdata(0));
         check("line irq",   int'(irq_line),   int'(m_irq[0]));
         check("div rdata",  int'(rdata_div),  exp_rdata(1));
         check("div irq",    int'(irq_div),    int'(m_irq[1]));
      end
   end

   task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1'b1;
      @(negedge clk); wr = 1'b0; addr = 2'd0;
   endtask

   task automatic bus_rd(input logic [1:0] a);
      @(negedge clk); addr = a; rd = 1'b1;
      @(negedge clk); rd = 1'b0; addr = 2'd0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary;
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(64'd20 * 64'd200000);
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      cur_req = "R1";
      idle(3);
      rst_n = 1'b1;
      bus_rd(2'd1);
      bus_rd(2'd2);
      cur_req = "R2";
      bus_wr(2'd0, 16'h1234);
      idle(4);
      bus_rd(2'd0);
      cur_req = "R4";
      bus_wr(2'd0, 16'hFFFC);
      idle(6);
      cur_req = "R7";
      bus_rd(2'd1);
      bus_rd(2'd1);
      cur_req = "R9";
      bus_wr(2'd2, 16'h0020);
      idle(3);
      cur_req = "R5";
      bus_wr(2'd1, 16'h0008);
      idle(45);
      bus_wr(2'd1, 16'h0000);
      bus_wr(2'd0, 16'h001A);
      idle(10);
      cur_req = "R6";
      bus_wr(2'd1, 16'h0008);
      bus_wr(2'd2, 16'h0003);
      for (int i = 0; i < 12; i++) bus_rd(2'd1);
      cur_req = "R10";
      bus_wr(2'd1, 16'h0018);
      idle(20);
      bus_wr(2'd1, 16'h0020);
      bus_wr(2'd0, 16'hFFF8);
      idle(12);
      bus_wr(2'd0, 16'hFFF8);
      idle(12);
      cur_req = "R11";
      bus_wr(2'd2, 16'h0004);
      bus_wr(2'd1, 16'h0058);
      idle(20);
      cur_req = "R3";
      bus_wr(2'd1, 16'h0100);
      idle(30);
      bus_wr(2'd1, 16'h0200);
      idle(40);
      bus_wr(2'd1, 16'h0300);
      idle(20);
      for (int f = 0; f < 4; f++) begin
         cur_req = "R12/R13";
         bus_wr(2'd1, 16'((f << 1) | 1));
         idle(60);
         bus_rd(2'd0);
      end
      cur_req = "R8";
      bus_wr(2'd1, 16'hFFFF);
      bus_rd(2'd1);
      idle(30);
      summary();
   end

endmodule